// File: doc/BRIEF.md
# Watchdog Timer with Write-Once-Window Mode Register

This block is a retriggerable one-shot watchdog. It sleeps after power-on until software issues its first refresh. From then on, the counter advances on the selected tick, and every refresh sends it back to zero. If software stops refreshing, the counter reaches the terminal value for the chosen tap and the block drives a one-cycle reset pulse. That pulse also clears the counter and disarms the watchdog.

A small mode register sets four things: the timeout tap, whether counting continues while the processor is halted, whether it continues while the processor is stopped, and which clock source drives the counter. The two sources are an internal RC tick, modelled as a clock-enable input, and an external crystal tick. The register accepts writes only during a short window after power-on reset. After that window the configuration is fixed until the next power-on.

Top module: `wdog_core`

## Requirements
- R1: After power-on reset, the read value is 0xED and the reset output is low. In that value, tap = 01, the halt-run bit = 1, the stop-run bit = 1 and the source bit = 0.
- R2: Before the first refresh, no number of ticks produces a reset pulse.
- R3: A refresh restarts the count from zero. After the cycle that carries the refresh, the pulse comes exactly one full timeout later.
- R4: With the external source selected, the tap field in bits 1:0 selects a timeout of 256, 512, 1024 or 4096 ticks (codes 00, 01, 10, 11). The pulse appears on the cycle after the terminal tick.
- R5: With the internal RC source selected, the tap codes 00, 01, 10 and 11 select 5, 15, 25 and 100 ms. Each millisecond is RC_TICKS_PER_MS RC ticks, which gives 160, 480, 800 and 3200 ticks at the default of 32.
- R6: The reset pulse lasts one cycle. Afterwards the watchdog stays disarmed and the mode register keeps its contents.
- R7: Writes are accepted only during the first WIN_CYCLES (64) clock cycles after reset release. Later writes leave the read value unchanged.
- R8: When bit 2 (halt-run) is 0 and the halt input is high, counting is frozen. When bit 2 is 1, halt has no effect.
- R9: When bit 3 (stop-run) is 0 and the stop input is high, counting is frozen.
- R10: Bits 7:5 always read as 1, and writes to them have no effect.
- R11: Bit 4 selects the count source: 0 for the RC tick, 1 for the crystal tick. The unselected tick is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write data |
| cfg_rdata | output | 8 | Mode register read value |
| kick | input | 1 | Refresh strobe; arms the watchdog and clears its count |
| halt_st | input | 1 | Processor is in HALT |
| stop_st | input | 1 | Processor is in STOP |
| rc_tick | input | 1 | Internal RC oscillator tick enable |
| xtal_tick | input | 1 | External crystal tick enable |
| wd_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The timeout is measured for every tap code under both sources, with only the selected tick toggling. This shows whether the tap decode and the RC scaling are right, and whether the source multiplexer picks the right input. Further runs vary the refresh timing: no refresh at all, and a refresh in mid-count. These separate the arming logic from a counter that simply free-runs. Halt and stop episodes, with the matching run bit cleared and then set, show whether the two gates are wired to the correct bits. Writes placed inside and after the configuration window show whether the window counter closes the register.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef struct packed {
    logic       src_xtal;
    logic       stop_run;
    logic       halt_run;
    logic [1:0] tap;
  } wdog_mode_t;

  localparam logic [1:0] TAP_RST  = 2'b01;
  localparam logic [2:0] HI_ONES  = 3'b111;

  function automatic int unsigned ext_term(input logic [1:0] tap);
    case (tap)
      2'b00:   return 256;
      2'b01:   return 512;
      2'b10:   return 1024;
      default: return 4096;
    endcase
  endfunction

  function automatic int unsigned rc_ms(input logic [1:0] tap);
    case (tap)
      2'b00:   return 5;
      2'b01:   return 15;
      2'b10:   return 25;
      default: return 100;
    endcase
  endfunction

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdog_mode_reg.sv
module wdog_mode_reg
  import wdog_pkg::*;
#(
  parameter int WIN_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output wdog_mode_t mode_o,
  output logic [7:0] rd_data_o
);
  localparam int WIN_W = $clog2(WIN_CYCLES + 1);
  localparam logic [WIN_W-1:0] WIN_LIM = WIN_W'(WIN_CYCLES);

  logic [WIN_W-1:0] win_q, win_d;
  wdog_mode_t       mode_q, mode_d;
  logic             win_open;
  logic             unused_hi;

  assign win_open  = (win_q < WIN_LIM);
  assign unused_hi = ^wr_data_i[7:5];

  always_comb begin
    win_d  = win_q;
    mode_d = mode_q;
    if (win_open) begin
      win_d = win_q + 1'b1;
      if (wr_en_i) mode_d = wdog_mode_t'(wr_data_i[4:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      mode_q <= '{src_xtal: 1'b0, stop_run: 1'b1, halt_run: 1'b1, tap: TAP_RST};
    end else begin
      win_q  <= win_d;
      mode_q <= mode_d;
    end
  end

  assign mode_o    = mode_q;
  assign rd_data_o = {HI_ONES, mode_q};
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int RC_TICKS_PER_MS = 32,
  parameter int CNT_W           = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  wdog_mode_t mode_i,
  input  logic       kick_i,
  input  logic       halt_i,
  input  logic       stop_i,
  input  logic       rc_tick_i,
  input  logic       xtal_tick_i,
  output logic       fire_o
);
  localparam int TW = CNT_W + 1;

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fire_q, fire_d;
  logic [TW-1:0]    term, cnt_inc;
  logic             tick_sel, frozen, adv;

  always_comb begin
    if (mode_i.src_xtal) term = TW'(ext_term(mode_i.tap));
    else                 term = TW'(rc_ms(mode_i.tap) * RC_TICKS_PER_MS);
  end

  assign tick_sel = mode_i.src_xtal ? xtal_tick_i : rc_tick_i;
  assign frozen   = (halt_i & ~mode_i.halt_run) | (stop_i & ~mode_i.stop_run);
  assign adv      = armed_q & tick_sel & ~frozen;
  assign cnt_inc  = {1'b0, cnt_q} + TW'(1);

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    fire_d  = 1'b0;
    if (kick_i) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (adv) begin
      if (cnt_inc >= term) begin
        fire_d  = 1'b1;
        armed_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d   = cnt_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      fire_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      fire_q  <= fire_d;
    end
  end

  assign fire_o = fire_q;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int WIN_CYCLES      = 64,
  parameter int RC_TICKS_PER_MS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       kick,
  input  logic       halt_st,
  input  logic       stop_st,
  input  logic       rc_tick,
  input  logic       xtal_tick,
  output logic       wd_rst_o
);
  localparam int RC_MAX   = 100 * RC_TICKS_PER_MS;
  localparam int MAX_TERM = (RC_MAX > 4096) ? RC_MAX : 4096;
  localparam int CNT_W    = $clog2(MAX_TERM);

  logic       rst_sync_n;
  wdog_mode_t mode;

  wdog_rst_sync #(.STAGES(2)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdog_mode_reg #(.WIN_CYCLES(WIN_CYCLES)) u_mode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (cfg_wr),
    .wr_data_i (cfg_wdata),
    .mode_o    (mode),
    .rd_data_o (cfg_rdata)
  );

  wdog_count #(.RC_TICKS_PER_MS(RC_TICKS_PER_MS), .CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .mode_i      (mode),
    .kick_i      (kick),
    .halt_i      (halt_st),
    .stop_i      (stop_st),
    .rc_tick_i   (rc_tick),
    .xtal_tick_i (xtal_tick),
    .fire_o      (wd_rst_o)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int WIN_CYCLES = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_rdata,
  input logic       kick,
  input logic       halt_st,
  input logic       stop_st,
  input logic       wd_rst_o
);
  localparam int WIN_W = $clog2(WIN_CYCLES + 1);
  localparam logic [WIN_W-1:0] WIN_LIM = WIN_W'(WIN_CYCLES);

  logic [WIN_W-1:0] age_q;
  logic             live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= '0;
      live_q <= 1'b0;
    end else begin
      if (age_q != WIN_LIM) age_q <= age_q + 1'b1;
      if (kick)             live_q <= 1'b1;
      else if (wd_rst_o)    live_q <= 1'b0;
    end
  end

  // R2
  fire_needs_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_o |-> live_q);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_o |=> !wd_rst_o);

  // R7
  window_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == WIN_LIM) |=> $stable(cfg_rdata));

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_st && !cfg_rdata[2] && !kick) |=> !wd_rst_o);

  // R9
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_st && !cfg_rdata[3] && !kick) |=> !wd_rst_o);

  // R10
  high_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7:5] == 3'b111);
endmodule

bind wdog_core wdog_chk #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cfg_rdata (cfg_rdata),
  .kick      (kick),
  .halt_st   (halt_st),
  .stop_st   (stop_st),
  .wd_rst_o  (wd_rst_o)
);

// File: tb/test_wdog_core.sv
`timescale 1ns/1ps
module test_wdog_core;
  localparam int TPM = 32;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       kick, halt_st, stop_st, rc_tick, xtal_tick;
  logic       wd_rst_o;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  wdog_core #(.WIN_CYCLES(64), .RC_TICKS_PER_MS(TPM)) i_wdog_core (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .kick(kick), .halt_st(halt_st), .stop_st(stop_st),
    .rc_tick(rc_tick), .xtal_tick(xtal_tick), .wd_rst_o(wd_rst_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic por();
    @(negedge clk);
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; kick = 1'b0;
    halt_st = 1'b0; stop_st = 1'b0; rc_tick = 1'b0; xtal_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_kick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic measure(input int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(negedge clk);
      n++;
      if (wd_rst_o) break;
    end
  endtask

  task automatic count_pulses(input int cyc, output int p);
    p = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (wd_rst_o) p++;
    end
  endtask

  task automatic t_reset();
    por();
    check(cfg_rdata == 8'hED, "R1 read value", cfg_rdata, 8'hED);
    check(wd_rst_o == 1'b0, "R1 output low", wd_rst_o, 0);
  endtask

  task automatic t_idle();
    int p;
    por();
    rc_tick = 1'b1; xtal_tick = 1'b1;
    count_pulses(6000, p);
    check(p == 0, "R2 no pulse before first kick", p, 0);
  endtask

  task automatic t_ext_taps();
    int exp_t[4] = '{256, 512, 1024, 4096};
    int n;
    for (int t = 0; t < 4; t++) begin
      por();
      wr(8'h0C | 8'h10 | 8'(t));
      check(cfg_rdata == (8'hFC | 8'(t)), "R10 high bits read one", cfg_rdata, 8'hFC | t);
      xtal_tick = 1'b1;
      do_kick();
      measure(5000, n);
      check(n == exp_t[t] && wd_rst_o, "R4 external tap timeout", n, exp_t[t]);
    end
  endtask

  task automatic t_rc_taps();
    int ms[4] = '{5, 15, 25, 100};
    int n, p;
    for (int t = 0; t < 4; t++) begin
      por();
      wr(8'h0C | 8'(t));
      rc_tick = 1'b1;
      do_kick();
      measure(5000, n);
      check(n == ms[t] * TPM && wd_rst_o, "R5 RC tap timeout", n, ms[t] * TPM);
    end
    por();
    wr(8'h1C);
    rc_tick = 1'b1;
    do_kick();
    count_pulses(5000, p);
    check(p == 0, "R11 RC tick ignored on crystal source", p, 0);
    por();
    wr(8'h0C);
    xtal_tick = 1'b1;
    do_kick();
    count_pulses(5000, p);
    check(p == 0, "R11 crystal tick ignored on RC source", p, 0);
  endtask

  task automatic t_refresh();
    int n;
    por();
    wr(8'h1C);
    xtal_tick = 1'b1;
    do_kick();
    repeat (200) @(negedge clk);
    do_kick();
    measure(1000, n);
    check(n == 256 && wd_rst_o, "R3 kick restarts count", n, 256);
  endtask

  task automatic t_pulse();
    int n, p;
    por();
    wr(8'h1C);
    xtal_tick = 1'b1;
    do_kick();
    measure(1000, n);
    check(n == 256, "R6 first timeout", n, 256);
    @(negedge clk);
    check(wd_rst_o == 1'b0, "R6 pulse one cycle", wd_rst_o, 0);
    count_pulses(3000, p);
    check(p == 0, "R6 disarmed after pulse", p, 0);
    check(cfg_rdata == 8'hFC, "R6 mode kept", cfg_rdata, 8'hFC);
  endtask

  task automatic t_window();
    por();
    repeat (100) @(negedge clk);
    wr(8'h12);
    check(cfg_rdata == 8'hED, "R7 late write ignored", cfg_rdata, 8'hED);
    por();
    repeat (40) @(negedge clk);
    wr(8'hF2);
    check(cfg_rdata == 8'hF2, "R7 early write taken, R10 high bits", cfg_rdata, 8'hF2);
  endtask

  task automatic t_halt();
    int n, p;
    por();
    wr(8'h18);
    xtal_tick = 1'b1;
    do_kick();
    repeat (100) @(negedge clk);
    halt_st = 1'b1;
    count_pulses(500, p);
    check(p == 0, "R8 frozen in halt", p, 0);
    halt_st = 1'b0;
    measure(1000, n);
    check(n == 156 && wd_rst_o, "R8 resumes after halt", n, 156);
    por();
    wr(8'h1C);
    xtal_tick = 1'b1; halt_st = 1'b1;
    do_kick();
    measure(1000, n);
    check(n == 256 && wd_rst_o, "R8 runs in halt when enabled", n, 256);
  endtask

  task automatic t_stop();
    int n, p;
    por();
    wr(8'h14);
    xtal_tick = 1'b1;
    do_kick();
    repeat (100) @(negedge clk);
    stop_st = 1'b1;
    count_pulses(500, p);
    check(p == 0, "R9 frozen in stop", p, 0);
    stop_st = 1'b0;
    measure(1000, n);
    check(n == 156 && wd_rst_o, "R9 resumes after stop", n, 156);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; kick = 1'b0;
    halt_st = 1'b0; stop_st = 1'b0; rc_tick = 1'b0; xtal_tick = 1'b0;
    t_reset();
    t_idle();
    t_ext_taps();
    t_rc_taps();
    t_refresh();
    t_pulse();
    t_window();
    t_halt();
    t_stop();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule